// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block is a set-associative branch target table used by the fetch stage. In the same cycle as an instruction fetch, it looks up the fetch address and produces a prediction. If a valid entry with a matching tag is present, the branch is predicted taken and the stored target becomes the next fetch address. If no such entry is present, the prediction is not-taken and the next fetch address is the sequential one. No direction counters are used: an entry being present is the whole of the taken prediction.

The execute stage reports resolved branches through a separate update port. A taken branch is written into the table, or refreshed if it is already there, and becomes the most recently used way of its set. A branch that resolves not-taken and is present in the table is removed. When a new entry is needed, an empty way is filled first; if the set is full, the least recently used way is replaced. A lookup hit also counts as a use of that way. If an update arrives in the same cycle, the update alone decides the recency order for that cycle.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is empty, so every lookup misses until a taken update installs an entry.
- R2: With default parameters, the set index is PC[7:2] and the tag is PC[31:8]. A lookup with `lk_valid`=1 sets `lk_hit`=1 in the same cycle when a valid way of the indexed set holds that tag, and `lk_target` then shows that way's stored target.
- R3: `lk_next_pc` equals `lk_target` on a hit and `lk_pc`+4 otherwise. `lk_hit` is 0 whenever `lk_valid`=0.
- R4: A taken update (`upd_valid`=1, `upd_taken`=1) for a branch that is absent from its set is written into the lowest-numbered empty way. If the set has no empty way, it replaces the least recently used way. The written way becomes most recently used.
- R5: A taken update for a branch already present overwrites its target in the same way and makes that way most recently used. No second copy is created.
- R6: A not-taken update (`upd_taken`=0) removes a matching entry. If no entry matches, it changes nothing.
- R7: A lookup hit with no update in the same cycle makes the hit way most recently used.
- R8: In any cycle with `upd_valid`=1, the lookup does not change the recency order.
- R9: An update changes only the set that its own PC indexes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_pc | input | 32 | Fetch address to look up |
| lk_hit | output | 1 | Predicted taken (entry present) |
| lk_target | output | 32 | Stored target of the hitting entry |
| lk_next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Resolved target address |
| upd_taken | input | 1 | Branch resolved taken (1) or not taken (0) |

## Verification
Four things are checked on every cycle by assertions: that lookups miss right after reset, that `lk_next_pc` is chosen correctly from the hit/miss outcome, that a lookup of a branch just written by a taken update hits with the new target, and that a lookup of a branch just removed by a not-taken update misses. Which way gets replaced can only be seen over a series of operations, so the bench scenarios cover it. They fill a set, change its recency through lookups and updates, and then check which branch is gone after a third branch is inserted. The same approach covers the update-over-lookup priority and the isolation of other sets.

// File: rtl/btb_pkg.sv
// Package: constants shared by the branch target buffer modules.
// Assumes instructions are 4-byte aligned, so the low PC bits carry no index information.
package btb_pkg;
    localparam int INSTR_ALIGN_BITS = 2;
    localparam int INSTR_BYTES      = 4;
endpackage

// File: rtl/btb_way.sv
// Module: one way of the table, holding the valid, tag and target arrays of all sets.
// Provides a lookup read port and an update read port. Writes and invalidates
// land on the update index. Assumes wr_en and inv_en are never high together.
module btb_way #(
    parameter int SETS  = 64,
    parameter int TAG_W = 24,
    parameter int PC_W  = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    output logic             a_valid,
    output logic [TAG_W-1:0] a_tag,
    output logic [PC_W-1:0]  a_tgt,
    input  logic [IDX_W-1:0] b_idx,
    output logic             b_valid,
    output logic [TAG_W-1:0] b_tag,
    input  logic             wr_en,
    input  logic             inv_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_tgt
);
    logic [SETS-1:0]  valid_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic [PC_W-1:0]  tgt_q [SETS];

    // Valid bits: cleared by reset, set on a write, cleared on an invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n)      valid_q <= '0;
        else if (wr_en)  valid_q[b_idx] <= 1'b1;
        else if (inv_en) valid_q[b_idx] <= 1'b0;
    end

    // Tag and target storage: written only on an install or refresh.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[b_idx] <= wr_tag;
            tgt_q[b_idx] <= wr_tgt;
        end
    end

    // Read ports: combinational reads for the lookup and the update side.
    always_comb begin
        a_valid = valid_q[a_idx];
        a_tag   = tag_q[a_idx];
        a_tgt   = tgt_q[a_idx];
        b_valid = valid_q[b_idx];
        b_tag   = tag_q[b_idx];
    end
endmodule

// File: rtl/btb_lru.sv
// Module: true-LRU recency ranks for each set (rank 0 = most recent).
// It also picks a replacement victim: the lowest-numbered empty way if one exists,
// otherwise the way of highest rank. Assumes WAYS >= 2.
module btb_lru #(
    parameter int SETS = 64,
    parameter int WAYS = 2,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [IDX_W-1:0] vic_idx,
    input  logic [WAYS-1:0]  vic_valid,
    output logic [WAY_W-1:0] victim
);
    logic [WAY_W-1:0] rank_q [SETS][WAYS];

    // Rank update: the touched way goes to rank 0, and more recent ways age by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    rank_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    rank_q[touch_idx][w] <= '0;
                else if (rank_q[touch_idx][w] < rank_q[touch_idx][touch_way])
                    rank_q[touch_idx][w] <= rank_q[touch_idx][w] + 1'b1;
            end
        end
    end

    // Victim choice: the first empty way wins, otherwise the oldest way.
    always_comb begin
        logic found;
        victim = '0;
        found  = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!vic_valid[w] && !found) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++)
                if (rank_q[vic_idx][w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
        end
    end
endmodule

// File: rtl/btb_predictor.sv
// Module: top of the set-associative branch target buffer.
// Lookups are combinational, in the fetch cycle. Updates take effect at the next
// clock edge. An update has priority over the lookup's recency refresh.
// Assumes word-aligned PCs and WAYS >= 2.
module btb_predictor #(
    parameter int PC_W = 32,
    parameter int SETS = 64,
    parameter int WAYS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_target,
    output logic [PC_W-1:0] lk_next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_taken
);
    import btb_pkg::*;

    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int IDX_LO = INSTR_ALIGN_BITS;
    localparam int TAG_LO = IDX_LO + IDX_W;
    localparam int TAG_W  = PC_W - TAG_LO;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             a_valid [WAYS];
    logic [TAG_W-1:0] a_tag   [WAYS];
    logic [PC_W-1:0]  a_tgt   [WAYS];
    logic [WAYS-1:0]  b_valid;
    logic [TAG_W-1:0] b_tag   [WAYS];
    logic [WAYS-1:0]  lk_match, up_match, wr_en, inv_en;
    logic [WAY_W-1:0] lk_way, up_way, victim, wr_way, touch_way;
    logic [IDX_W-1:0] touch_idx;
    logic             up_hit, touch_en;
    logic [PC_W-1:0]  hit_tgt;
    logic             upd_low_unused;

    assign upd_low_unused = ^upd_pc[IDX_LO-1:0];

    // Field split: the set index and tag of both ports.
    always_comb begin
        lk_idx = lk_pc[TAG_LO-1:IDX_LO];
        lk_tag = lk_pc[PC_W-1:TAG_LO];
        up_idx = upd_pc[TAG_LO-1:IDX_LO];
        up_tag = upd_pc[PC_W-1:TAG_LO];
    end

    // Storage: one instance per way, with per-way tag compare for both ports.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        btb_way #(.SETS(SETS), .TAG_W(TAG_W), .PC_W(PC_W)) u_way (
            .clk(clk), .rst_n(rst_n),
            .a_idx(lk_idx), .a_valid(a_valid[w]), .a_tag(a_tag[w]), .a_tgt(a_tgt[w]),
            .b_idx(up_idx), .b_valid(b_valid[w]), .b_tag(b_tag[w]),
            .wr_en(wr_en[w]), .inv_en(inv_en[w]),
            .wr_tag(up_tag), .wr_tgt(upd_target)
        );
        assign lk_match[w] = a_valid[w] && (a_tag[w] == lk_tag);
        assign up_match[w] = b_valid[w] && (b_tag[w] == up_tag);
        assign wr_en[w]    = upd_valid && upd_taken && (wr_way == WAY_W'(w));
        assign inv_en[w]   = upd_valid && !upd_taken && up_match[w];
    end

    // Way select: the hit way and its target on the lookup side, the hit way on the update side.
    always_comb begin
        lk_way  = '0;
        hit_tgt = '0;
        up_way  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_match[w]) begin
                lk_way  = WAY_W'(w);
                hit_tgt = a_tgt[w];
            end
            if (up_match[w]) up_way = WAY_W'(w);
        end
    end

    assign up_hit = |up_match;
    assign wr_way = up_hit ? up_way : victim;

    // Prediction outputs: presence means taken; otherwise fall through to the next word.
    always_comb begin
        lk_hit     = lk_valid && (|lk_match);
        lk_target  = hit_tgt;
        lk_next_pc = lk_hit ? hit_tgt : lk_pc + PC_W'(INSTR_BYTES);
    end

    // Recency source: a taken update, else a lookup hit when no update is present.
    always_comb begin
        touch_en  = 1'b0;
        touch_idx = lk_idx;
        touch_way = lk_way;
        if (upd_valid) begin
            touch_en  = upd_taken;
            touch_idx = up_idx;
            touch_way = wr_way;
        end else if (lk_hit) begin
            touch_en = 1'b1;
        end
    end

    btb_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_idx(touch_idx), .touch_way(touch_way),
        .vic_idx(up_idx), .vic_valid(b_valid), .victim(victim)
    );
endmodule

// File: rtl/btb_predictor_chk.sv
// Checker: port-level properties of the branch target buffer, bound to the top module.
// Assumes the synchronous active-low reset of the top.
module btb_predictor_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_hit,
    input logic [PC_W-1:0] lk_target,
    input logic [PC_W-1:0] lk_next_pc,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic [PC_W-1:0] upd_target,
    input logic            upd_taken
);
    // R1: the first cycle after reset sees an empty table.
    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !lk_hit);

    // R3: no hit without a lookup, and a miss falls through to the next word.
    p_hit_needs_lookup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit);
    p_fallthrough_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit) |-> (lk_next_pc == lk_pc + PC_W'(4)));
    p_redirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_next_pc == lk_target));

    // R4 / R5: a branch just written by a taken update hits with the new target.
    p_taken_installs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_valid && upd_taken) && lk_valid && lk_pc == $past(upd_pc))
        |-> (lk_hit && lk_target == $past(upd_target)));

    // R6: a branch just removed by a not-taken update misses.
    p_not_taken_removes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_valid && !upd_taken) && lk_valid && lk_pc == $past(upd_pc))
        |-> !lk_hit);
endmodule

bind btb_predictor btb_predictor_chk #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .lk_hit(lk_hit), .lk_target(lk_target), .lk_next_pc(lk_next_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
    .upd_taken(upd_taken)
);

// File: tb/btb_predictor_bench.sv
// Bench: a vector table walked by one loop, then directed reset and corner-case tests.
module btb_predictor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit;
    logic [31:0] lk_target, lk_next_pc;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic [31:0] upd_target = '0;
    logic        upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    btb_predictor u_btb_predictor (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
        .lk_hit(lk_hit), .lk_target(lk_target), .lk_next_pc(lk_next_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
        .upd_taken(upd_taken)
    );

    // upd=1: update with taken/val as target; upd=0: lookup expecting hit and next PC = val.
    typedef struct packed {
        logic        upd;
        logic        taken;
        logic [31:0] pc;
        logic [31:0] val;
        logic        hit;
        logic [7:0]  req;
    } vec_t;

    // Set 1: A=0x1004, B=0x2004, C=0x3004. Set 2: D=0x1008.
    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 32'h1004, 32'h1008, 1'b0, 8'd1},  // R1 empty table
        '{1'b1, 1'b1, 32'h1004, 32'h5000, 1'b0, 8'd4},  // R4 install A into way 0
        '{1'b0, 1'b0, 32'h1004, 32'h5000, 1'b1, 8'd2},  // R2 hit A
        '{1'b0, 1'b0, 32'h2004, 32'h2008, 1'b0, 8'd3},  // R3 fall-through B
        '{1'b1, 1'b1, 32'h2004, 32'h6000, 1'b0, 8'd4},  // R4 B into empty way
        '{1'b0, 1'b0, 32'h2004, 32'h6000, 1'b1, 8'd2},  // R2 hit B
        '{1'b0, 1'b0, 32'h1004, 32'h5000, 1'b1, 8'd7},  // R7 hit refreshes A
        '{1'b1, 1'b1, 32'h3004, 32'h7000, 1'b0, 8'd4},  // R4 C replaces LRU (B)
        '{1'b0, 1'b0, 32'h2004, 32'h2008, 1'b0, 8'd7},  // R7 B evicted
        '{1'b0, 1'b0, 32'h1004, 32'h5000, 1'b1, 8'd7},  // R7 A kept
        '{1'b0, 1'b0, 32'h3004, 32'h7000, 1'b1, 8'd4},  // R4 C present
        '{1'b1, 1'b1, 32'h1004, 32'h5100, 1'b0, 8'd5},  // R5 retarget A
        '{1'b0, 1'b0, 32'h1004, 32'h5100, 1'b1, 8'd5},  // R5 new target
        '{1'b1, 1'b0, 32'h3004, 32'h0000, 1'b0, 8'd6},  // R6 remove C
        '{1'b0, 1'b0, 32'h3004, 32'h3008, 1'b0, 8'd6},  // R6 C gone
        '{1'b0, 1'b0, 32'h1008, 32'h100C, 1'b0, 8'd9},  // R9 set 2 still empty
        '{1'b1, 1'b1, 32'h1008, 32'h8000, 1'b0, 8'd9},  // R9 install D
        '{1'b0, 1'b0, 32'h1008, 32'h8000, 1'b1, 8'd9},  // R9 hit D
        '{1'b0, 1'b0, 32'h1004, 32'h5100, 1'b1, 8'd9}   // R9 set 1 untouched
    };

    // Compare one value and record the result.
    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One-cycle update, applied at the next rising edge.
    task automatic do_update(input logic [31:0] pc, input logic [31:0] tgt, input logic tk);
        @(negedge clk);
        lk_valid = 1'b0; upd_valid = 1'b1; upd_pc = pc; upd_target = tgt; upd_taken = tk;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    // Lookup: outputs checked in the same cycle; the recency refresh lands at the next edge.
    task automatic do_lookup(input logic [31:0] pc, input logic hit, input logic [31:0] nxt, input string req);
        @(negedge clk);
        upd_valid = 1'b0; lk_valid = 1'b1; lk_pc = pc;
        #1;
        chk(req, "lk_hit", {31'd0, lk_hit}, {31'd0, hit});
        chk(req, "lk_next_pc", lk_next_pc, nxt);
        if (hit) chk(req, "lk_target", lk_target, nxt);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, several sets miss.
        do_lookup(32'h0000_1004, 1'b0, 32'h0000_1008, "R1");
        do_lookup(32'hFFFF_FFFC, 1'b0, 32'h0000_0000, "R1");

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].upd) do_update(VECS[i].pc, VECS[i].val, VECS[i].taken);
            else do_lookup(VECS[i].pc, VECS[i].hit, VECS[i].val, $sformatf("R%0d", VECS[i].req));
        end

        // R3: no lookup means no hit even for a present branch.
        @(negedge clk);
        lk_valid = 1'b0; lk_pc = 32'h1004;
        #1 chk("R3", "lk_hit idle", {31'd0, lk_hit}, 32'd0);

        // R8: set 5, E=0x1014, F=0x2014, G=0x3014.
        do_update(32'h1014, 32'h9000, 1'b1);
        do_update(32'h2014, 32'h9100, 1'b1);
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = 32'h1014;
        upd_valid = 1'b1; upd_pc = 32'h2014; upd_target = 32'h9100; upd_taken = 1'b1;
        #1 chk("R8", "lk_hit concurrent", {31'd0, lk_hit}, 32'd1);
        @(negedge clk);
        upd_valid = 1'b0; lk_valid = 1'b0;
        do_update(32'h3014, 32'h9200, 1'b1);
        do_lookup(32'h1014, 1'b0, 32'h1018, "R8");
        do_lookup(32'h2014, 1'b1, 32'h9100, "R8");
        do_lookup(32'h3014, 1'b1, 32'h9200, "R4");

        // R6: a not-taken update for an absent branch changes nothing.
        do_update(32'h4014, 32'h0, 1'b0);
        do_lookup(32'h2014, 1'b1, 32'h9100, "R6");
        do_lookup(32'h3014, 1'b1, 32'h9200, "R6");

        // R1: reset in mid-run empties the table.
        @(negedge clk);
        lk_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_lookup(32'h1004, 1'b0, 32'h1008, "R1");
        do_lookup(32'h1008, 1'b0, 32'h100C, "R1");

        @(negedge clk);
        lk_valid = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule